// File: doc/BRIEF.md
# Three-Wire-Plus-Ready Serial EEPROM Command Master

This block sits on the host side of a small serial EEPROM with a select line, a serial clock, a data line into the device and a data line out of it. A client asks for one job at a time on a parallel request port. The job is a read or write of one or more consecutive 16-bit words, or a lone command that enables or disables programming. The block turns the job into one framed command per word, with a gap between words, and handles the serial-clock timing. For reads it collects and returns each word. For writes it waits, by polling, until the device reports that programming is complete.

Every command starts with a start bit of 1 and a two-bit device opcode. After the opcode comes the address, most significant bit first. A write adds the data word after the address. Commands that enable or disable programming use the device opcode 00 and place a two-bit sub-code in the top two address positions, with zeros below. A burst write is always wrapped: an enable command before the first word and a disable command after the last word. The address is 6 or 8 bits wide. A parameter selects the width, and the frame lengths follow from it.

Top module: `mw_eeprom_master`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `busy`, `done`, `rd_valid` and `wr_take` are all low.
- R2: A request is taken only while `busy` is low. A `req_valid` pulse during a job adds no command on the serial lines and no second `done`.
- R3: `req_op` = 00 is a read. For each word the block sends 1, 1, 0, then the address MSB first, while `ee_cs` is high. It then gives 17 more serial clocks and samples `ee_do` before each rising edge. The first sample is the device's leading zero and is dropped. The 16 later samples form `rd_data`, MSB first, and `rd_valid` is pulsed for one cycle.
- R4: A job of N words sends N commands at addresses A, A+1, …, A+N-1. Before each command, `ee_cs` stays low through at least one full serial-clock period.
- R5: `req_op` = 01 is a write. Each word command is 1, 0, 1, then the address, then 16 data bits MSB first. `wr_data` is loaded when that command starts, and `wr_take` is pulsed once per word in that cycle.
- R6: A write job sends, in order: a write-enable command (1, 0, 0, then 1, 1 in the top two address bits and zeros below), then the word commands, then a write-disable command (same form with 0, 0 in the top two address bits).
- R7: After the write data, `ee_cs` goes low for one serial-clock period and then high again. The block keeps clocking, and goes on only after it samples `ee_do` high.
- R8: `req_op` = 10 sends one write-enable command and `req_op` = 11 sends one write-disable command. The address is 3+ADDR_W bits long in total, and all bits below the sub-code are zero.
- R9: `ee_sk` stays high for at least ceil(SK_HIGH_NS·CLK_MHZ/1000) system cycles and low for at least ceil(SK_LOW_NS·CLK_MHZ/1000) cycles. `ee_di` and `ee_cs` do not change while `ee_sk` is high.
- R10: If `ee_do` is not seen high within POLL_LIMIT serial clocks of polling, the job stops. `error` rises together with `done`, and `ee_cs` is low. No further command is sent. `error` stays high until the next request is taken.
- R11: Each job, whether it completes or stops on error, ends with exactly one `done` pulse that lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_op | input | 2 | 00 read, 01 write, 10 enable programming, 11 disable programming |
| req_addr | input | ADDR_W | First word address |
| req_count | input | CNT_W | Number of words (0 behaves as 1) |
| wr_data | input | DATA_W | Word to program, loaded at each wr_take |
| wr_take | output | 1 | Pulse: wr_data loaded for the current word |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| error | output | 1 | Ready poll timed out on the last job |
| rd_data | output | DATA_W | Word read from the device |
| rd_valid | output | 1 | Pulse: rd_data holds a new word |
| ee_cs | output | 1 | Device select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data into the device |
| ee_do | input | 1 | Serial data and ready status from the device |

## Verification
The bench builds the block with the 8-bit address variant, so the enable and disable commands are 11 bits long and write commands are 27 bits long. With the clock widths set to 24 ns high and 16 ns low at 125 MHz, each serial clock lasts only five system cycles. This makes multi-word bursts, random jobs and the minimum-width checks on the serial clock cheap to run. POLL_LIMIT is set to 12, so a behavioural device that stays busy too long reaches the timeout path within a few dozen serial clocks, while a short busy time shows the exact number of poll clocks.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_WEN   = 2'b10,
      OP_WDS   = 2'b11
   } mw_req_e;

   typedef enum logic [2:0] {
      PH_IDLE, PH_GAP, PH_SEND, PH_RECV, PH_PAUSE, PH_POLL
   } mw_phase_e;

   typedef enum logic [1:0] {
      STG_PRE, STG_MAIN, STG_POST
   } mw_stage_e;

   localparam logic [1:0] DEV_READ  = 2'b10;
   localparam logic [1:0] DEV_WRITE = 2'b01;
   localparam logic [1:0] DEV_EXT   = 2'b00;
   localparam logic [1:0] SUB_WEN   = 2'b11;
   localparam logic [1:0] SUB_WDS   = 2'b00;

endpackage

// File: rtl/mw_slot_timer.sv
module mw_slot_timer #(
   parameter int HI_CYC = 94,
   parameter int LO_CYC = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sk,
   output logic samp,
   output logic slot_end
);
   localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt;
   logic          hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi  <= 1'b0;
         cnt <= '0;
      end else if (!run) begin
         hi  <= 1'b0;
         cnt <= '0;
      end else if (!hi) begin
         if (cnt == CW'(LO_CYC - 1)) begin
            hi  <= 1'b1;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt == CW'(HI_CYC - 1)) begin
            hi  <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign sk       = hi;
   assign samp     = run && !hi && (cnt == CW'(LO_CYC - 1));
   assign slot_end = run && hi && (cnt == CW'(HI_CYC - 1));

   // run-length checker for the serial clock
   logic [CW-1:0] hi_len, lo_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
         lo_len <= CW'(LO_CYC);
      end else begin
         hi_len <= sk ? ((hi_len == CW'(HI_CYC)) ? hi_len : hi_len + 1'b1) : '0;
         lo_len <= !sk ? ((lo_len == CW'(LO_CYC)) ? lo_len : lo_len + 1'b1) : '0;
      end
   end

   assert_sk_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sk) |-> (hi_len >= CW'(HI_CYC)));
   assert_sk_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sk) |-> (lo_len >= CW'(LO_CYC)));

endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build import mw_pkg::*; #(
   parameter int AW = 6,
   parameter int DW = 16,
   localparam int FW   = 3 + AW + DW,
   localparam int LENW = $clog2(FW + 1)
) (
   input  mw_req_e         cmd,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   data,
   output logic [FW-1:0]   frame,
   output logic [LENW-1:0] len,
   output logic            is_rd,
   output logic            is_wr
);
   localparam int SHORT = 3 + AW;

   always_comb begin
      is_rd = 1'b0;
      is_wr = 1'b0;
      len   = LENW'(SHORT);
      unique case (cmd)
         OP_READ: begin
            frame = {1'b1, DEV_READ, addr, {DW{1'b0}}};
            is_rd = 1'b1;
         end
         OP_WRITE: begin
            frame = {1'b1, DEV_WRITE, addr, data};
            len   = LENW'(FW);
            is_wr = 1'b1;
         end
         OP_WEN:  frame = {1'b1, DEV_EXT, SUB_WEN, {(AW-2){1'b0}}, {DW{1'b0}}};
         default: frame = {1'b1, DEV_EXT, SUB_WDS, {(AW-2){1'b0}}, {DW{1'b0}}};
      endcase
   end

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master import mw_pkg::*; #(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 8,
   parameter int CLK_MHZ    = 125,
   parameter int SK_HIGH_NS = 750,
   parameter int SK_LOW_NS  = 250,
   parameter int POLL_LIMIT = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CNT_W-1:0]  req_count,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_take,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);
   localparam int HI_RAW = (SK_HIGH_NS * CLK_MHZ + 999) / 1000;
   localparam int LO_RAW = (SK_LOW_NS * CLK_MHZ + 999) / 1000;
   localparam int HI_CYC = (HI_RAW < 1) ? 1 : HI_RAW;
   localparam int LO_CYC = (LO_RAW < 1) ? 1 : LO_RAW;
   localparam int FW     = 3 + ADDR_W + DATA_W;
   localparam int LENW   = $clog2(FW + 1);
   localparam int RCW    = $clog2(DATA_W + 1);
   localparam int PW     = $clog2(POLL_LIMIT + 1);

   generate
      if (ADDR_W != 6 && ADDR_W != 8) begin : g_bad_aw
         $error("ADDR_W must be 6 or 8");
      end
      if (POLL_LIMIT < 1 || CNT_W < 1 || DATA_W < 1) begin : g_bad_cfg
         $error("POLL_LIMIT, CNT_W and DATA_W must be positive");
      end
   endgenerate

   mw_phase_e         phase;
   mw_stage_e         stage;
   mw_req_e           op_q, cur_cmd;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [FW-1:0]     shreg, frm;
   logic [LENW-1:0]   bits_q, frm_len;
   logic              fr_rd, fr_wr, frm_rd, frm_wr;
   logic [DATA_W:0]   rd_sh;
   logic [RCW-1:0]    rcnt;
   logic [PW-1:0]     poll_q;
   logic              ready_q;
   logic              sk_i, samp, slot_end;

   mw_slot_timer #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .sk(sk_i), .samp(samp), .slot_end(slot_end));

   always_comb begin
      unique case (stage)
         STG_PRE:  cur_cmd = OP_WEN;
         STG_POST: cur_cmd = OP_WDS;
         default:  cur_cmd = op_q;
      endcase
   end

   mw_frame_build #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
      .cmd(cur_cmd), .addr(addr_q), .data(wr_data),
      .frame(frm), .len(frm_len), .is_rd(frm_rd), .is_wr(frm_wr));

   // what follows the current command
   mw_stage_e         adv_stage;
   mw_phase_e         adv_phase;
   logic [CNT_W-1:0]  adv_left;
   logic [ADDR_W-1:0] adv_addr;
   logic              adv_fin;

   always_comb begin
      adv_stage = stage;
      adv_left  = left_q;
      adv_addr  = addr_q;
      adv_fin   = 1'b0;
      unique case (stage)
         STG_PRE: adv_stage = STG_MAIN;
         STG_MAIN: begin
            if (left_q == CNT_W'(1)) begin
               if (op_q == OP_WRITE) adv_stage = STG_POST;
               else                  adv_fin   = 1'b1;
            end else begin
               adv_left = left_q - 1'b1;
               adv_addr = addr_q + 1'b1;
            end
         end
         default: adv_fin = 1'b1;
      endcase
      adv_phase = adv_fin ? PH_IDLE : PH_GAP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         stage    <= STG_MAIN;
         op_q     <= OP_READ;
         addr_q   <= '0;
         left_q   <= '0;
         shreg    <= '0;
         bits_q   <= '0;
         fr_rd    <= 1'b0;
         fr_wr    <= 1'b0;
         rd_sh    <= '0;
         rcnt     <= '0;
         poll_q   <= '0;
         ready_q  <= 1'b0;
         done     <= 1'b0;
         error    <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         wr_take  <= 1'b0;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         wr_take  <= 1'b0;
         unique case (phase)
            PH_IDLE: if (req_valid) begin
               op_q   <= mw_req_e'(req_op);
               addr_q <= req_addr;
               left_q <= (req_count == '0) ? CNT_W'(1) : req_count;
               stage  <= (mw_req_e'(req_op) == OP_WRITE) ? STG_PRE : STG_MAIN;
               error  <= 1'b0;
               phase  <= PH_GAP;
            end
            PH_GAP: if (slot_end) begin
               shreg   <= frm;
               bits_q  <= frm_len;
               fr_rd   <= frm_rd;
               fr_wr   <= frm_wr;
               wr_take <= frm_wr;
               phase   <= PH_SEND;
            end
            PH_SEND: if (slot_end) begin
               shreg  <= shreg << 1;
               bits_q <= bits_q - 1'b1;
               if (bits_q == LENW'(1)) begin
                  if (fr_rd) begin
                     phase <= PH_RECV;
                     rcnt  <= '0;
                  end else if (fr_wr) begin
                     phase <= PH_PAUSE;
                  end else begin
                     phase  <= adv_phase;
                     stage  <= adv_stage;
                     left_q <= adv_left;
                     addr_q <= adv_addr;
                     done   <= adv_fin;
                  end
               end
            end
            PH_RECV: begin
               if (samp) rd_sh <= {rd_sh[DATA_W-1:0], ee_do};
               if (slot_end) begin
                  if (rcnt == RCW'(DATA_W)) begin
                     rd_valid <= 1'b1;
                     rd_data  <= rd_sh[DATA_W-1:0];
                     phase    <= adv_phase;
                     stage    <= adv_stage;
                     left_q   <= adv_left;
                     addr_q   <= adv_addr;
                     done     <= adv_fin;
                  end else begin
                     rcnt <= rcnt + 1'b1;
                  end
               end
            end
            PH_PAUSE: if (slot_end) begin
               phase   <= PH_POLL;
               poll_q  <= '0;
               ready_q <= 1'b0;
            end
            PH_POLL: begin
               if (samp && ee_do) ready_q <= 1'b1;
               if (slot_end) begin
                  if (ready_q) begin
                     phase  <= adv_phase;
                     stage  <= adv_stage;
                     left_q <= adv_left;
                     addr_q <= adv_addr;
                     done   <= adv_fin;
                  end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                     phase <= PH_IDLE;
                     error <= 1'b1;
                     done  <= 1'b1;
                  end else begin
                     poll_q <= poll_q + 1'b1;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy  = (phase != PH_IDLE);
   assign ee_cs = (phase == PH_SEND) || (phase == PH_RECV) || (phase == PH_POLL);
   assign ee_sk = sk_i;
   assign ee_di = (phase == PH_SEND) && shreg[FW-1];

   assert_lines_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk && $past(ee_sk)) |-> ($stable(ee_di) && $stable(ee_cs)));
   assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(op_q) && $stable(stage) == $stable(stage)));
   assert_rdv_after_recv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(phase == PH_RECV));
   assert_take_at_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> ((phase == PH_SEND) && $past(phase == PH_GAP)));
   assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> (done && !ee_cs && !busy));
   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/mw_eeprom_master_test.sv
module mw_eeprom_master_test;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int CW = 8;
   localparam int HI = 3;
   localparam int LO = 2;
   localparam int PL = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [CW-1:0] req_count = '0;
   logic [DW-1:0] wr_data = '0;
   logic wr_take, busy, done, error, rd_valid, ee_cs, ee_sk, ee_di, ee_do;
   logic [DW-1:0] rd_data;

   always #4 clk = ~clk;

   mw_eeprom_master #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .CLK_MHZ(125),
      .SK_HIGH_NS(24), .SK_LOW_NS(16), .POLL_LIMIT(PL)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_count(req_count), .wr_data(wr_data),
      .wr_take(wr_take), .busy(busy), .done(done), .error(error),
      .rd_data(rd_data), .rd_valid(rd_valid), .ee_cs(ee_cs), .ee_sk(ee_sk),
      .ee_di(ee_di), .ee_do(ee_do));

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] init_word(input int a);
      return 16'(a * 16'h1357) ^ 16'hA5C3;
   endfunction

   // ---------------- behavioural device ----------------
   localparam int M_RX = 0, M_OUT = 1, M_WD = 2, M_WAIT = 3, M_POLL = 4, M_IGN = 5;
   logic [15:0] dev_mem [256];
   logic [15:0] exp_mem [256];
   int          dmode = M_RX;
   int          dn = 0, dn2 = 0, didx = 0;
   logic [AW+2:0] dsh = '0;
   logic [AW-1:0] da = '0;
   logic [15:0] dout = '0, wdat = '0;
   logic        do_q = 1'b0, wen = 1'b0, cs_prev = 1'b0;
   int          prog_busy = 0, dev_busy = 3, poll_rises = 0, last_poll = 0;
   int          gap_rises = 0, gap_viol = 0, start_bad = 0, ext_bad = 0;
   int          log_kind [64];
   int          log_addr [64];
   int          log_data [64];
   int          log_n = 0;

   assign ee_do = (dmode == M_POLL) ? (ee_cs && prog_busy == 0) : do_q;

   task automatic dlog(input int k, input int a, input int d);
      if (log_n < 64) begin
         log_kind[log_n] = k; log_addr[log_n] = a; log_data[log_n] = d;
      end
      log_n++;
   endtask

   always @(posedge ee_sk or posedge ee_cs or negedge ee_cs) begin
      if (ee_cs !== cs_prev) begin
         if (ee_cs) begin
            if (gap_rises < 1) gap_viol++;
         end else begin
            if (dmode == M_WAIT) begin
               dmode = M_POLL; prog_busy = dev_busy; poll_rises = 0;
            end else begin
               if (dmode == M_POLL) last_poll = poll_rises;
               dmode = M_RX; prog_busy = 0;
            end
            dn = 0; dsh = '0; do_q = 1'b0;
         end
         gap_rises = 0;
         cs_prev = ee_cs;
      end else if (!ee_cs) begin
         gap_rises++;
      end else begin
         case (dmode)
            M_RX: begin
               dsh = {dsh[AW+1:0], ee_di};
               dn++;
               if (dn == 1 && !ee_di) start_bad++;
               if (dn == 3 + AW) begin
                  da = dsh[AW-1:0];
                  case (dsh[AW+1:AW])
                     2'b10: begin
                        dmode = M_OUT; dout = dev_mem[da]; didx = 16; do_q = 1'b0;
                        dlog(0, int'(da), 0);
                     end
                     2'b01: begin dmode = M_WD; dn2 = 0; end
                     2'b00: begin
                        if (da[AW-3:0] != '0) ext_bad++;
                        if (da[AW-1:AW-2] == 2'b11) begin wen = 1'b1; dlog(2, 0, 0); end
                        else if (da[AW-1:AW-2] == 2'b00) begin wen = 1'b0; dlog(3, 0, 0); end
                        else dlog(4, 0, 0);
                        dmode = M_IGN;
                     end
                     default: begin dlog(4, 0, 0); dmode = M_IGN; end
                  endcase
               end
            end
            M_OUT: begin
               if (didx > 0) begin do_q = dout[didx-1]; didx--; end
               else do_q = 1'b0;
            end
            M_WD: begin
               wdat = {wdat[14:0], ee_di};
               dn2++;
               if (dn2 == 16) begin
                  dlog(1, int'(da), int'(wdat));
                  if (wen) dev_mem[da] = wdat;
                  dmode = M_WAIT;
               end
            end
            M_POLL: begin
               poll_rises++;
               if (prog_busy > 0) prog_busy--;
            end
            default: ;
         endcase
      end
   end

   // ---------------- serial clock timing monitor ----------------
   int hi_run = 0, lo_run = 0, tim_viol = 0;
   logic sk_p = 1'b0, di_p = 1'b0, cs_p = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (ee_sk && sk_p && (ee_di !== di_p || ee_cs !== cs_p)) tim_viol++;
         if (!ee_sk && sk_p && hi_run < HI) tim_viol++;
         if (ee_sk && !sk_p && lo_run < LO) tim_viol++;
         if (ee_sk) begin hi_run = sk_p ? hi_run + 1 : 1; lo_run = 0; end
         else       begin lo_run = sk_p ? 1 : lo_run + 1; hi_run = 0; end
      end
      sk_p = ee_sk; di_p = ee_di; cs_p = ee_cs;
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   bit timed_out = 1'b0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !timed_out) begin
         timed_out = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   // ---------------- job driver ----------------
   logic [15:0] wr_words [8];
   logic [15:0] rd_buf [8];
   int nrd, ntake, ndone;

   task automatic run_op(input logic [1:0] op, input int a, input int n, input bit inject);
      int guard;
      bit seen;
      log_n = 0; nrd = 0; ntake = 0; ndone = 0;
      wr_data = wr_words[0];
      @(negedge clk);
      req_op = op; req_addr = AW'(a); req_count = CW'(n); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0; seen = 1'b0;
      while (!seen && guard < 20000) begin
         if (inject && guard == 20) begin req_valid = 1'b1; req_op = 2'b11; end
         if (inject && guard == 21) req_valid = 1'b0;
         @(negedge clk);
         guard++;
         if (rd_valid && nrd < 8) begin rd_buf[nrd] = rd_data; nrd++; end
         if (wr_take) begin ntake++; wr_data = wr_words[ntake % 8]; end
         if (done) begin ndone++; seen = 1'b1; end
      end
      req_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (6) begin
         @(negedge clk);
         if (done) ndone++;
      end
   endtask

   int r;
   initial begin
      for (int i = 0; i < 256; i++) begin
         dev_mem[i] = init_word(i);
         exp_mem[i] = init_word(i);
      end
      for (int i = 0; i < 8; i++) wr_words[i] = '0;
      r = $urandom(32'd2024);
      repeat (4) @(negedge clk);
      chk(ee_cs == 1'b0 && ee_sk == 1'b0, "R1 serial lines in reset", {ee_cs, ee_sk}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
      chk(!rd_valid && !wr_take, "R1 strobes after reset", {rd_valid, wr_take}, 0);

      // standalone enable
      run_op(2'b10, 0, 1, 1'b0); settle();
      chk(log_n == 1 && log_kind[0] == 2, "R8 enable command", log_kind[0], 2);
      chk(wen == 1'b1 && ext_bad == 0, "R8 enable sub-code and zero fill", ext_bad, 0);
      chk(ndone == 1, "R11 one done per job", ndone, 1);

      // single read
      run_op(2'b00, 5, 1, 1'b0); settle();
      chk(nrd == 1 && rd_buf[0] == exp_mem[5], "R3 single read word", rd_buf[0], exp_mem[5]);
      chk(log_n == 1 && log_kind[0] == 0 && log_addr[0] == 5, "R3 read frame address", log_addr[0], 5);

      // multi read
      run_op(2'b00, 200, 4, 1'b0); settle();
      chk(nrd == 4, "R4 word count", nrd, 4);
      for (int i = 0; i < 4; i++) begin
         chk(rd_buf[i] == exp_mem[200+i], "R4 burst read word", rd_buf[i], exp_mem[200+i]);
         chk(log_addr[i] == 200 + i, "R4 successive address", log_addr[i], 200 + i);
      end

      // burst write
      dev_busy = 3;
      wr_words[0] = 16'hBEEF; wr_words[1] = 16'h0001; wr_words[2] = 16'h8000;
      run_op(2'b01, 16, 3, 1'b0); settle();
      chk(log_n == 5, "R6 command count", log_n, 5);
      chk(log_kind[0] == 2 && log_kind[4] == 3, "R6 enable first, disable last",
          log_kind[0] * 16 + log_kind[4], 16'h23);
      for (int i = 0; i < 3; i++) begin
         chk(log_kind[i+1] == 1 && log_addr[i+1] == 16 + i, "R5 write address", log_addr[i+1], 16 + i);
         chk(log_data[i+1] == int'(wr_words[i]), "R5 write data MSB first", log_data[i+1], wr_words[i]);
         exp_mem[16+i] = wr_words[i];
      end
      chk(ntake == 3, "R5 one take per word", ntake, 3);
      chk(last_poll == dev_busy + 1, "R7 poll until ready", last_poll, dev_busy + 1);
      chk(ndone == 1 && !error, "R11 write job ends once", ndone, 1);

      // read back
      run_op(2'b00, 16, 3, 1'b0); settle();
      for (int i = 0; i < 3; i++)
         chk(rd_buf[i] == exp_mem[16+i], "R5 programmed word read back", rd_buf[i], exp_mem[16+i]);

      // standalone disable
      run_op(2'b11, 0, 1, 1'b0); settle();
      chk(log_n == 1 && log_kind[0] == 3 && wen == 1'b0, "R8 disable command", log_kind[0], 3);

      // request while busy
      run_op(2'b00, 100, 2, 1'b1); settle();
      chk(log_n == 2 && log_kind[1] == 0, "R2 extra request ignored", log_n, 2);
      chk(ndone == 1, "R2 no second done", ndone, 1);

      // poll timeout
      dev_busy = 1000;
      wr_words[0] = 16'h1234;
      run_op(2'b01, 40, 2, 1'b0);
      chk(error == 1'b1, "R10 error on timeout", error, 1);
      chk(ee_cs == 1'b0, "R10 select released", ee_cs, 0);
      settle();
      chk(log_n == 2 && log_kind[1] == 1, "R10 nothing sent after abort", log_n, 2);
      chk(ndone == 1, "R11 single done on abort", ndone, 1);
      exp_mem[40] = 16'h1234;
      dev_busy = 2;
      run_op(2'b00, 41, 1, 1'b0); settle();
      chk(error == 1'b0, "R10 error cleared by next job", error, 0);
      chk(rd_buf[0] == exp_mem[41], "R3 read after abort", rd_buf[0], exp_mem[41]);

      // random mix
      for (int k = 0; k < 8; k++) begin
         int a, n;
         bit wr;
         a = int'($urandom_range(0, 250));
         n = int'($urandom_range(1, 3));
         wr = 1'($urandom_range(0, 1));
         if (wr) begin
            for (int i = 0; i < n; i++) wr_words[i] = 16'($urandom);
            run_op(2'b01, a, n, 1'b0); settle();
            for (int i = 0; i < n; i++) exp_mem[a+i] = wr_words[i];
            chk(log_n == n + 2 && ntake == n && ndone == 1, "R6 random write framing", log_n, n + 2);
         end else begin
            run_op(2'b00, a, n, 1'b0); settle();
            chk(nrd == n && ndone == 1, "R4 random read count", nrd, n);
            for (int i = 0; i < n; i++)
               chk(rd_buf[i] == exp_mem[a+i], "R3 random read word", rd_buf[i], exp_mem[a+i]);
         end
      end

      chk(tim_viol == 0, "R9 serial clock widths and line hold", tim_viol, 0);
      chk(gap_viol == 0, "R4 select gap between commands", gap_viol, 0);
      chk(start_bad == 0, "R3 start bit", start_bad, 0);
      chk(ext_bad == 0, "R6 extended address zero fill", ext_bad, 0);

      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule